// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit integer core fetches next. Each cycle it takes the current program counter, two register operands, an already sign-extended immediate and a decoded flow class. From these it produces the next program counter, a flag that says whether control flow left the sequential path, and the link value that a jump writes to its destination register. The flow class is one of four: sequential, conditional branch, PC-relative jump, or register-based jump. A branch also carries a 3-bit condition code.

Conditional branches and PC-relative jumps read the immediate in halfword units, so the offset added to the PC is twice the immediate. A register-based jump adds the immediate to the first operand without scaling and then clears bit 0 of the sum. All address arithmetic wraps modulo 2^W.

The decision path is combinational. When `REG_PC` is set, a program-counter register with synchronous active-low reset loads the computed next PC on every clock edge.

Top module: `bjt_nextpc_unit`

## Requirements
- R1: When `flow_i` is 00 (sequential), `taken_o` is 0 and `next_pc_o` equals `pc_i` + 4.
- R2: When `flow_i` is 01 (branch), `cond_i` 000 is taken when the operands are equal, and 001 is taken when they differ.
- R3: `cond_i` 100 is taken when `opa_i` < `opb_i` as signed two's-complement values, and 101 is taken when `opa_i` >= `opb_i` as signed values.
- R4: `cond_i` 110 is taken when `opa_i` < `opb_i` as unsigned values, and 111 is taken when `opa_i` >= `opb_i` as unsigned values.
- R5: `cond_i` 010 and 011 never take the branch, whatever the operands are.
- R6: A taken branch sets `next_pc_o` = `pc_i` + 2*`imm_i`. A branch that is not taken sets `next_pc_o` = `pc_i` + 4.
- R7: When `flow_i` is 10 (PC-relative jump), `taken_o` is 1 and `next_pc_o` = `pc_i` + 2*`imm_i`.
- R8: When `flow_i` is 11 (register jump), `taken_o` is 1 and `next_pc_o` is `opa_i` + `imm_i` with bit 0 forced to 0.
- R9: `link_o` equals `pc_i` + 4 for every flow class.
- R10: All sums wrap modulo 2^32. For example, `pc_i` = 0xFFFFFFFC in sequential flow gives 0.
- R11: With `REG_PC` = 1, `pc_q_o` takes the value `RESET_PC` at a clock edge where `rst_n` is low. At every other edge it loads the `next_pc_o` value present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional PC register |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | W | Current program counter |
| opa_i | input | W | First register operand (compare left side, jump base) |
| opb_i | input | W | Second register operand (compare right side) |
| imm_i | input | W | Sign-extended immediate |
| flow_i | input | 2 | Flow class: 00 sequential, 01 branch, 10 PC-relative jump, 11 register jump |
| cond_i | input | 3 | Branch condition code |
| next_pc_o | output | W | Next program counter |
| taken_o | output | 1 | Control flow left the sequential path |
| link_o | output | W | Return address for the destination register |
| pc_q_o | output | W | Registered PC (same as `next_pc_o` when `REG_PC` = 0) |

## Verification
The bench builds the block with W = 32, `REG_PC` = 1 and `RESET_PC` = 0x00000100. With the register present, the bench can compare the registered PC against the expected target of the previous cycle and observe the reset value at the ports. With 32-bit width, the bench reaches the wrap cases at the top of the address space and the operand pairs where the signed and unsigned compares disagree, such as 0x80000000 against 1.

// File: rtl/bjt_pkg.sv
// Shared definitions for the next-PC unit: flow classes and condition codes.
// Assumes the decoder produces the 2-bit flow class and the 3-bit compare code.
package bjt_pkg;
    typedef enum logic [1:0] {
        FLOW_SEQ     = 2'b00,
        FLOW_BRANCH  = 2'b01,
        FLOW_JUMP    = 2'b10,
        FLOW_JUMPREG = 2'b11
    } flow_e;

    localparam logic [2:0] CC_EQ  = 3'b000;
    localparam logic [2:0] CC_NE  = 3'b001;
    localparam logic [2:0] CC_LT  = 3'b100;
    localparam logic [2:0] CC_GE  = 3'b101;
    localparam logic [2:0] CC_LTU = 3'b110;
    localparam logic [2:0] CC_GEU = 3'b111;
endpackage

// File: rtl/bjt_branch_cmp.sv
// Operand comparator for conditional branches.
// Evaluates one of six signed/unsigned relations selected by cc_i.
// Assumes the two unused codes (010, 011) must give a false result.
module bjt_branch_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   cc_i,
    output logic         hit_o
);
    import bjt_pkg::*;

    logic eq;
    logic lt_s;
    logic lt_u;

    // Basic relations shared by all condition codes
    always_comb begin
        eq   = (a_i == b_i);
        lt_s = ($signed(a_i) < $signed(b_i));
        lt_u = (a_i < b_i);
    end

    // Select the relation named by the condition code
    always_comb begin
        unique case (cc_i)
            CC_EQ:   hit_o = eq;
            CC_NE:   hit_o = !eq;
            CC_LT:   hit_o = lt_s;
            CC_GE:   hit_o = !lt_s;
            CC_LTU:  hit_o = lt_u;
            CC_GEU:  hit_o = !lt_u;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bjt_target_add.sv
// Address adder: base plus offset, with the offset optionally doubled
// and bit 0 of the sum optionally cleared. The sum wraps modulo 2^W.
// SHIFT and CLR_LSB are fixed per instance.
module bjt_target_add #(
    parameter int W       = 32,
    parameter bit SHIFT   = 1'b0,
    parameter bit CLR_LSB = 1'b0
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] off_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] off_eff;
    logic [W-1:0] raw;

    generate
        if (SHIFT) begin : g_scaled
            assign off_eff = {off_i[W-2:0], 1'b0};
        end else begin : g_plain
            assign off_eff = off_i;
        end
    endgenerate

    // Modular sum of base and effective offset
    always_comb raw = base_i + off_eff;

    generate
        if (CLR_LSB) begin : g_even
            assign sum_o = {raw[W-1:1], 1'b0};
        end else begin : g_keep
            assign sum_o = raw;
        end
    endgenerate
endmodule

// File: rtl/bjt_nextpc_unit.sv
// Next-PC unit. Selects the sequential, branch, PC-relative jump or
// register-jump target and produces the link address.
// Assumes imm_i is already sign-extended and, for PC-relative forms,
// counted in halfwords. REG_PC adds a PC register with synchronous
// active-low reset.
module bjt_nextpc_unit #(
    parameter int          W          = 32,
    parameter int          INSN_BYTES = 4,
    parameter bit          REG_PC     = 1'b1,
    parameter logic [W-1:0] RESET_PC  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [W-1:0] imm_i,
    input  logic [1:0]   flow_i,
    input  logic [2:0]   cond_i,
    output logic [W-1:0] next_pc_o,
    output logic         taken_o,
    output logic [W-1:0] link_o,
    output logic [W-1:0] pc_q_o
);
    import bjt_pkg::*;

    localparam logic [W-1:0] STEP = W'(INSN_BYTES);

    flow_e        flow;
    logic         cmp_hit;
    logic [W-1:0] rel_tgt;
    logic [W-1:0] reg_tgt;

    // Decode the flow class
    always_comb flow = flow_e'(flow_i);

    // Return address: the instruction after the current one
    always_comb link_o = pc_i + STEP;

    bjt_branch_cmp #(.W(W)) u_cmp (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .cc_i  (cond_i),
        .hit_o (cmp_hit)
    );

    bjt_target_add #(.W(W), .SHIFT(1'b1), .CLR_LSB(1'b0)) u_rel (
        .base_i (pc_i),
        .off_i  (imm_i),
        .sum_o  (rel_tgt)
    );

    bjt_target_add #(.W(W), .SHIFT(1'b0), .CLR_LSB(1'b1)) u_reg (
        .base_i (opa_i),
        .off_i  (imm_i),
        .sum_o  (reg_tgt)
    );

    // Choose the next PC and the taken flag from the flow class
    always_comb begin
        unique case (flow)
            FLOW_BRANCH: begin
                taken_o   = cmp_hit;
                next_pc_o = cmp_hit ? rel_tgt : link_o;
            end
            FLOW_JUMP: begin
                taken_o   = 1'b1;
                next_pc_o = rel_tgt;
            end
            FLOW_JUMPREG: begin
                taken_o   = 1'b1;
                next_pc_o = reg_tgt;
            end
            default: begin
                taken_o   = 1'b0;
                next_pc_o = link_o;
            end
        endcase
    end

    generate
        if (REG_PC) begin : g_pc_reg
            logic [W-1:0] pc_q;
            // PC register: synchronous reset, otherwise follow the next PC
            always_ff @(posedge clk) begin
                if (!rst_n) pc_q <= RESET_PC;
                else        pc_q <= next_pc_o;
            end
            assign pc_q_o = pc_q;

            a_r11_pc_follows: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> pc_q_o == $past(next_pc_o))
                else $error("R11: PC register did not load the previous next PC");
        end else begin : g_pc_comb
            assign pc_q_o = next_pc_o;
        end
    endgenerate

    a_r1_seq_stays: assert property (@(posedge clk) disable iff (!rst_n)
        flow_i == 2'b00 |-> !taken_o && next_pc_o == link_o)
        else $error("R1: sequential flow left the straight path");

    a_r5_unused_cc: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_i == 2'b01 && cond_i[2:1] == 2'b01) |-> !taken_o)
        else $error("R5: unused condition code took the branch");

    a_r6_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_i == 2'b01 && !taken_o) |-> next_pc_o == link_o)
        else $error("R6: untaken branch did not fall through");

    a_r7_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
        flow_i[1] |-> taken_o)
        else $error("R7: jump not flagged as taken");

    a_r8_even_target: assert property (@(posedge clk) disable iff (!rst_n)
        flow_i == 2'b11 |-> next_pc_o[0] == 1'b0)
        else $error("R8: register jump target has bit 0 set");
endmodule

// File: tb/test_bjt_nextpc_unit.sv
// Scoreboard bench: the driver applies a vector and queues its expected
// result, and the monitor pops and compares it after the following edge.
module test_bjt_nextpc_unit;
    localparam int          W    = 32;
    localparam logic [31:0] RPC  = 32'h0000_0100;

    typedef struct {
        logic [31:0] nxt;
        logic        tkn;
        logic [31:0] lnk;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0, opa_i = '0, opb_i = '0, imm_i = '0;
    logic [1:0]  flow_i = '0;
    logic [2:0]  cond_i = '0;
    logic [31:0] next_pc_o, link_o, pc_q_o;
    logic        taken_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    bjt_nextpc_unit #(.W(W), .INSN_BYTES(4), .REG_PC(1'b1), .RESET_PC(RPC)) i_bjt_nextpc_unit (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .opa_i(opa_i), .opb_i(opb_i),
        .imm_i(imm_i), .flow_i(flow_i), .cond_i(cond_i),
        .next_pc_o(next_pc_o), .taken_o(taken_o), .link_o(link_o), .pc_q_o(pc_q_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements
    function automatic exp_t model(logic [31:0] pc, logic [31:0] a, logic [31:0] b,
                                   logic [31:0] imm, logic [1:0] fl, logic [2:0] cc,
                                   string tag);
        exp_t e;
        bit hit;
        e.lnk = pc + 32'd4;
        e.tag = tag;
        case (cc)
            3'b000: hit = (a == b);
            3'b001: hit = (a != b);
            3'b100: hit = ($signed(a) <  $signed(b));
            3'b101: hit = ($signed(a) >= $signed(b));
            3'b110: hit = (a <  b);
            3'b111: hit = (a >= b);
            default: hit = 1'b0;
        endcase
        case (fl)
            2'b00: begin e.tkn = 1'b0; e.nxt = pc + 32'd4; end
            2'b01: begin e.tkn = hit;  e.nxt = hit ? pc + imm * 2 : pc + 32'd4; end
            2'b10: begin e.tkn = 1'b1; e.nxt = pc + imm * 2; end
            default: begin e.tkn = 1'b1; e.nxt = (a + imm) & 32'hFFFF_FFFE; end
        endcase
        return e;
    endfunction

    task automatic send(logic [31:0] pc, logic [31:0] a, logic [31:0] b,
                        logic [31:0] imm, logic [1:0] fl, logic [2:0] cc, string tag);
        @(negedge clk);
        pc_i = pc; opa_i = a; opb_i = b; imm_i = imm; flow_i = fl; cond_i = cc;
        sb.push_back(model(pc, a, b, imm, fl, cc, tag));
    endtask

    // Monitor: sample 2 ns after each edge, compare against the queued item.
    // The vector driven at the previous negedge is now settled, and the PC
    // register has just loaded that vector's next PC (R11).
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(next_pc_o == e.nxt, e.tag, "next_pc", next_pc_o, e.nxt);
                chk(taken_o == e.tkn, e.tag, "taken", {31'b0, taken_o}, {31'b0, e.tkn});
                chk(link_o == e.lnk, {e.tag, "/R9"}, "link", link_o, e.lnk);
                chk(pc_q_o == e.nxt, {e.tag, "/R11"}, "pc_q", pc_q_o, e.nxt);
            end
        end
    end

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R11 reset value
        @(negedge clk); @(negedge clk);
        chk(pc_q_o == RPC, "R11", "reset pc", pc_q_o, RPC);
        rst_n = 1'b1;

        send(32'h0000_1000, 0, 0, 0, 2'b00, 3'b000, "R1");
        send(32'h0000_2000, 32'd5, 32'd5, 32'd8, 2'b01, 3'b000, "R2");
        send(32'h0000_2000, 32'd5, 32'd6, 32'd8, 2'b01, 3'b000, "R2");
        send(32'h0000_2000, 32'd5, 32'd6, 32'hFFFF_FFF0, 2'b01, 3'b001, "R2");
        send(32'h0000_2000, 32'd7, 32'd7, 32'd4, 2'b01, 3'b001, "R2");
        send(32'h0000_3000, 32'h8000_0000, 32'd1, 32'd16, 2'b01, 3'b100, "R3");
        send(32'h0000_3000, 32'd1, 32'h8000_0000, 32'd16, 2'b01, 3'b101, "R3");
        send(32'h0000_3000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd16, 2'b01, 3'b101, "R3");
        send(32'h0000_3000, 32'h8000_0000, 32'd1, 32'd16, 2'b01, 3'b110, "R4");
        send(32'h0000_3000, 32'd1, 32'h8000_0000, 32'd16, 2'b01, 3'b110, "R4");
        send(32'h0000_3000, 32'h8000_0000, 32'd1, 32'd16, 2'b01, 3'b111, "R4");
        send(32'h0000_3000, 32'd3, 32'd3, 32'd16, 2'b01, 3'b010, "R5");
        send(32'h0000_3000, 32'd3, 32'd9, 32'd16, 2'b01, 3'b011, "R5");
        send(32'h0000_4000, 32'd2, 32'd9, 32'hFFFF_FF00, 2'b01, 3'b100, "R6");
        send(32'h0000_5000, 0, 0, 32'h0007_FFFF, 2'b10, 3'b000, "R7");
        send(32'h0000_5000, 0, 0, 32'hFFF8_0000, 2'b10, 3'b000, "R7");
        send(32'h0000_6000, 32'h0000_1001, 0, 32'd0, 2'b11, 3'b000, "R8");
        send(32'h0000_6000, 32'h0000_1000, 0, 32'hFFFF_F801, 2'b11, 3'b000, "R8");
        send(32'hFFFF_FFFC, 0, 0, 0, 2'b00, 3'b000, "R10");
        send(32'hFFFF_FFF0, 0, 0, 32'd16, 2'b10, 3'b000, "R10");
        send(32'h0000_0004, 32'hFFFF_FFFF, 0, 32'd5, 2'b11, 3'b000, "R10");

        // Drain the scoreboard
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule